// File: doc/BRIEF.md
# Load-Use Stall Interlock

This block is the front-end interlock of a five-stage in-order pipeline. It owns the program counter, the fetch/decode latch (the incremented address and the instruction word) and the instruction register that feeds the execute stage. Each cycle it compares the instruction waiting in decode with the instruction in execute. It stalls when the execute instruction is a load and the load's destination is a register that the decode instruction reads.

When it stalls, the PC and both fetch/decode registers reload their own values, so the fetch and decode stages repeat their work. The execute-stage instruction register is filled with an all-zero word, which is the no-op, so the stages further down keep moving and the load finishes its memory access. This arrangement assumes that load data is forwarded from the memory stage. With that forwarding, one bubble is enough, and the dependent instruction goes into execute on the following cycle.

Top module: `lui_interlock`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q`, `ifid_npc_q`, `ifid_ir_q` and `idex_ir_q` all become zero. The all-zero instruction word is the no-op.
- R2: In a cycle with no stall, the edge loads `pc_q` from `pc_next`, `ifid_npc_q` with the old `pc_q` + 4, `ifid_ir_q` from `fetch_instr`, and `idex_ir_q` from the old `ifid_ir_q`.
- R3: A stall occurs when the execute word's opcode (bits 31:26) equals the load code 6'h23, its destination field (bits 20:16) is nonzero, and that field equals the decode word's first source field (bits 25:21).
- R4: The decode word's bits 20:16 are compared as a second source only when its opcode is the register-register code 6'h00. For any other opcode, a match on those bits alone does not stall.
- R5: A load whose destination field is register 0 never causes a stall.
- R6: On a stall edge, `pc_q`, `ifid_npc_q` and `ifid_ir_q` keep their values, and `fetch_instr` and `pc_next` are ignored.
- R7: On a stall edge, `idex_ir_q` becomes all zeros.
- R8: A stall lasts exactly one cycle. On the next edge the held decode instruction moves into `idex_ir_q`.
- R9: An execute-stage instruction that is not a load never causes a stall, even when its bits 20:16 match a source of the decode instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction word read from instruction memory at `pc_q` |
| pc_next | input | ADDR_W | Address for the PC when there is no stall |
| pc_q | output | ADDR_W | Program counter |
| ifid_npc_q | output | ADDR_W | Fetch/decode latch: incremented address |
| ifid_ir_q | output | 32 | Fetch/decode latch: instruction being decoded |
| idex_ir_q | output | 32 | Instruction register feeding execute |

## Verification
The bench targets these corner cases:
- A match on the first source.
- A match on the second source of a register-register instruction.
- The same second-field match on an immediate instruction, which must not stall.
- A load writing register 0.
- A non-load producer with matching fields.

A detector that skips the opcode or register-0 qualification inserts bubbles that should not be there. A detector that misses the second source lets a stale operand through. The bench also replays a stall with changing fetch and next-address inputs. A design that fails to recycle the front-end latches loses an instruction or skips an address. A design that fails to clear the execute register runs the dependent instruction twice. The bench then checks that no second bubble follows.

// File: rtl/lui_pkg.sv
package lui_pkg;
  localparam int IW     = 32;
  localparam int OPC_W  = 6;
  localparam int RIDX_W = 5;
  localparam int OPC_MSB  = IW - 1;
  localparam int SRCA_MSB = OPC_MSB - OPC_W;
  localparam int SRCB_MSB = SRCA_MSB - RIDX_W;

  typedef logic [IW-1:0]     instr_t;
  typedef logic [OPC_W-1:0]  opc_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  localparam opc_t   OPC_RTYPE = 6'h00;
  localparam opc_t   OPC_LOAD  = 6'h23;
  localparam instr_t NOP_WORD  = '0;

  function automatic opc_t f_opc(input instr_t w);
    return w[OPC_MSB -: OPC_W];
  endfunction

  function automatic ridx_t f_srca(input instr_t w);
    return w[SRCA_MSB -: RIDX_W];
  endfunction

  // second register field: source of R-type, destination of I-type
  function automatic ridx_t f_srcb(input instr_t w);
    return w[SRCB_MSB -: RIDX_W];
  endfunction
endpackage

// File: rtl/lui_hazard_detect.sv
module lui_hazard_detect
  import lui_pkg::*;
#(
  parameter opc_t LOAD_OPC  = OPC_LOAD,
  parameter opc_t RTYPE_OPC = OPC_RTYPE
) (
  input  instr_t ex_ir,
  input  instr_t id_ir,
  output logic   stall
);
  logic  ex_is_load, dst_live, id_is_rr, hit_a, hit_b;
  ridx_t ex_dst;

  always_comb begin
    ex_is_load = (f_opc(ex_ir) == LOAD_OPC);
    ex_dst     = f_srcb(ex_ir);
    dst_live   = (ex_dst != '0);
    id_is_rr   = (f_opc(id_ir) == RTYPE_OPC);
    hit_a      = (f_srca(id_ir) == ex_dst);
    hit_b      = id_is_rr && (f_srcb(id_ir) == ex_dst);
    stall      = ex_is_load && dst_live && (hit_a || hit_b);
  end
endmodule

// File: rtl/lui_stage_reg.sv
module lui_stage_reg #(
  parameter int W      = 32,
  parameter bit BUBBLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stall,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (BUBBLE) begin : g_bubble
      // stall port selects the zero word (no-op)
      always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (stall) q <= '0;
        else            q <= d;
      end
    end else begin : g_hold
      // stall port selects the register's own value
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (!stall) q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/lui_interlock.sv
module lui_interlock
  import lui_pkg::*;
#(
  parameter int   ADDR_W    = 32,
  parameter int   PC_STEP   = 4,
  parameter opc_t LOAD_OPC  = OPC_LOAD,
  parameter opc_t RTYPE_OPC = OPC_RTYPE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     fetch_instr,
  input  logic [ADDR_W-1:0] pc_next,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] ifid_npc_q,
  output logic [IW-1:0]     ifid_ir_q,
  output logic [IW-1:0]     idex_ir_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic              stall;
  logic [ADDR_W-1:0] pc_inc;

  assign pc_inc = pc_q + STEP;

  lui_hazard_detect #(.LOAD_OPC(LOAD_OPC), .RTYPE_OPC(RTYPE_OPC)) u_det (
    .ex_ir (idex_ir_q),
    .id_ir (ifid_ir_q),
    .stall (stall)
  );

  lui_stage_reg #(.W(ADDR_W), .BUBBLE(1'b0)) u_pc (
    .clk(clk), .rst(rst), .stall(stall), .d(pc_next), .q(pc_q)
  );

  lui_stage_reg #(.W(ADDR_W), .BUBBLE(1'b0)) u_ifid_npc (
    .clk(clk), .rst(rst), .stall(stall), .d(pc_inc), .q(ifid_npc_q)
  );

  lui_stage_reg #(.W(IW), .BUBBLE(1'b0)) u_ifid_ir (
    .clk(clk), .rst(rst), .stall(stall), .d(fetch_instr), .q(ifid_ir_q)
  );

  lui_stage_reg #(.W(IW), .BUBBLE(1'b1)) u_idex_ir (
    .clk(clk), .rst(rst), .stall(stall), .d(ifid_ir_q), .q(idex_ir_q)
  );
endmodule

// File: rtl/lui_interlock_chk.sv
module lui_interlock_chk
  import lui_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic [IW-1:0]     fetch_instr,
  input logic [ADDR_W-1:0] pc_next,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] ifid_npc_q,
  input logic [IW-1:0]     ifid_ir_q,
  input logic [IW-1:0]     idex_ir_q
);
  logic ex_ld, ex_nz, m_a, m_b, id_rr;
  assign ex_ld = f_opc(idex_ir_q) == OPC_LOAD;
  assign ex_nz = f_srcb(idex_ir_q) != '0;
  assign m_a   = f_srca(ifid_ir_q) == f_srcb(idex_ir_q);
  assign m_b   = f_srcb(ifid_ir_q) == f_srcb(idex_ir_q);
  assign id_rr = f_opc(ifid_ir_q) == OPC_RTYPE;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && ifid_npc_q == '0 && ifid_ir_q == '0 && idex_ir_q == '0)); // R1

  AST_FLOW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !stall |=> (pc_q == $past(pc_next) && ifid_ir_q == $past(fetch_instr)
                && idex_ir_q == $past(ifid_ir_q))); // R2

  AST_SRCA_DETECT: assert property (@(posedge clk) disable iff (rst)
    (ex_ld && ex_nz && m_a) |-> stall); // R3

  AST_IMM_NO_SRCB: assert property (@(posedge clk) disable iff (rst)
    (!id_rr && !m_a) |-> !stall); // R4

  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    !ex_nz |-> !stall); // R5

  AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(pc_q) && $stable(ifid_npc_q) && $stable(ifid_ir_q))); // R6

  AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    stall |=> (idex_ir_q == '0)); // R7

  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R8

  AST_NONLOAD_FREE: assert property (@(posedge clk) disable iff (rst)
    !ex_ld |-> !stall); // R9
endmodule

bind lui_interlock lui_interlock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .fetch_instr(fetch_instr),
  .pc_next(pc_next), .pc_q(pc_q), .ifid_npc_q(ifid_npc_q),
  .ifid_ir_q(ifid_ir_q), .idex_ir_q(idex_ir_q)
);

// File: tb/sim_lui_interlock.sv
module sim_lui_interlock;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   fetch_instr = '0;
  logic [AW-1:0] pc_next = '0;
  logic [AW-1:0] pc_q, ifid_npc_q;
  logic [31:0]   ifid_ir_q, idex_ir_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [AW-1:0] m_pc = '0, m_npc = '0;
  logic [31:0]   m_ir = '0, m_ex = '0;

  always #4 clk = ~clk;

  lui_interlock #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .pc_next(pc_next),
    .pc_q(pc_q), .ifid_npc_q(ifid_npc_q), .ifid_ir_q(ifid_ir_q), .idex_ir_q(idex_ir_q)
  );

  // field layout: opcode 31:26, first reg 25:21, second reg 20:16, R-type dest 15:11
  function automatic logic [31:0] ld(input logic [4:0] rd, input logic [4:0] base);
    return {6'h23, base, rd, 16'h0010};
  endfunction
  function automatic logic [31:0] rr(input logic [4:0] rd, input logic [4:0] a, input logic [4:0] b);
    return {6'h00, a, b, rd, 11'h020};
  endfunction
  function automatic logic [31:0] im(input logic [4:0] rd, input logic [4:0] a);
    return {6'h08, a, rd, 16'h0007};
  endfunction

  // {fetch word, next address, expected stall}
  localparam int NV = 14;
  localparam logic [64:0] VEC [NV] = '{
    {ld(5'd5, 5'd1),          32'h04, 1'b0},
    {rr(5'd6, 5'd5, 5'd2),    32'h08, 1'b0},
    {im(5'd7, 5'd3),          32'h0C, 1'b1}, // R3 first-source hit
    {im(5'd7, 5'd3),          32'h0C, 1'b0}, // R8 resumes
    {ld(5'd9, 5'd4),          32'h10, 1'b0},
    {rr(5'd10, 5'd2, 5'd9),   32'h14, 1'b0},
    {im(5'd11, 5'd0),         32'h18, 1'b1}, // R4 second-source hit
    {im(5'd11, 5'd0),         32'h18, 1'b0},
    {ld(5'd0, 5'd3),          32'h40, 1'b0},
    {rr(5'd12, 5'd0, 5'd0),   32'h44, 1'b0},
    {ld(5'd14, 5'd2),         32'h48, 1'b0}, // R5 load to r0
    {im(5'd14, 5'd3),         32'h4C, 1'b0},
    {rr(5'd1, 5'd14, 5'd14),  32'h50, 1'b0}, // R4 immediate second field ignored
    {32'h0,                   32'h54, 1'b0}  // R9 non-load producer
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] f, input logic [AW-1:0] pn, input bit st);
    @(negedge clk);
    fetch_instr = f;
    pc_next     = pn;
    if (st) m_ex = '0;
    else begin
      m_ex  = m_ir;
      m_ir  = f;
      m_npc = m_pc + 32'd4;
      m_pc  = pn;
    end
    @(posedge clk);
    #1;
    check(st ? "R6 pc held"        : "R2 pc from next",  pc_q, m_pc);
    check(st ? "R6 npc held"       : "R2 npc = pc+4",    ifid_npc_q, m_npc);
    check(st ? "R6 ifid ir held"   : "R2 ifid ir fetch", ifid_ir_q, m_ir);
    check(st ? "R7 idex bubble"    : "R8 idex advance",  idex_ir_q, m_ex);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pc", pc_q, 32'h0);
    check("R1 reset npc", ifid_npc_q, 32'h0);
    check("R1 reset ifid", ifid_ir_q, 32'h0);
    check("R1 reset idex", idex_ir_q, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      step(VEC[i][64:33], VEC[i][32:1], VEC[i][0]);

    // R8 directed: stall with changing inputs, then single resume
    step(ld(5'd20, 5'd1), 32'h60, 1'b0);
    step(rr(5'd21, 5'd20, 5'd20), 32'h64, 1'b0);
    step(im(5'd22, 5'd0), 32'h68, 1'b1);
    step(32'hDEAD_BEEF, 32'h999, 1'b0);
    check("R8 dependent in execute", idex_ir_q, rr(5'd21, 5'd20, 5'd20));

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid reset pc", pc_q, 32'h0);
    check("R1 mid reset idex", idex_ir_q, 32'h0);
    check("R1 mid reset ifid", ifid_ir_q, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule